// File: doc/BRIEF.md
# Four-Wire Serial Memory Slave

This block is the slave end of a four-wire serial memory link: select, serial clock, data in and data out. A host raises select and clocks in a start bit, a two-bit opcode and an address, most significant bit first. The block then returns stored data, or collects write data into a page buffer. Every data-changing job is armed during the transfer but starts only when select falls. The job then runs for a fixed number of system clocks, with no serial clock needed. While it runs, a selected host sees busy on data out.

The array holds 1024 bits in registers. By default it is 128 bytes with a 7-bit address. Setting `WORD16` gives 64 sixteen-bit words with a 6-bit address. All serial inputs pass through synchronisers into the system clock domain. Each serial clock rising edge is one bit time.

Top module: `mw_mem_slave`

## Requirements
- R1: After reset, data out is low, every location reads as all ones and the write-enable latch is clear. Until an enable instruction arrives, write, erase, write-all and erase-all instructions start no job and change no location.
- R2: Opcode 00 with the two top address bits 11 sets the write-enable latch, and 00 with 00 clears it. The latch keeps its value across any number of other instructions. Reads work with the latch in either state.
- R3: A read is start bit 1, opcode 10 and an address. On the serial clock edge that carries the last address bit, data out goes to a dummy 0. Each later edge presents one data bit, MSB first.
- R4: While select stays high, a read runs on into the following addresses. After the highest address it continues at address 0.
- R5: A write is start bit 1, opcode 01 and an address, followed by one or more data words. Each complete word goes into a page buffer. The next word's index advances only in the low 4 bits (3 in the 16-bit organisation), so it wraps inside its page. Nothing reaches the array until select falls.
- R6: Opcode 11 with an address erases that one location to all ones. Opcode 00 with top address bits 10 erases every location to all ones.
- R7: Opcode 00 with top address bits 01, followed by one data word, writes that word to every location.
- R8: An armed job starts on the falling edge of select and keeps the block busy for `PROG_CYCLES` system clocks. While busy, a selected block drives data out low. After the job it drives data out high until select falls or a start bit arrives.
- R9: Dropping select discards any partial instruction and any incomplete data word. The next access needs a full start bit, opcode and address.
- R10: Serial clock edges that arrive while a job is running are ignored. They leave the latch, the array and the pending state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or ready/busy status to the host |

## Verification
Data out is registered behind a synchroniser and an edge detector. A data bit or the read dummy bit therefore appears about three system clocks after the serial clock rises. The bench holds each serial clock level for six system clocks and samples data out at the end of the high phase. A job's busy time begins three system clocks after select falls, and ready shows one clock after the job ends. The bench measures the interval from its own select fall to the first ready level and accepts a window of `PROG_CYCLES` to `PROG_CYCLES`+12 clocks. Ignored instructions are checked by holding select high for longer than a job would last, confirming that ready never appears, and then reading the locations back.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_READ, ST_WDATA, ST_WALL, ST_SKIP
  } mw_state_e;

  typedef enum logic [2:0] {
    JOB_NONE, JOB_PAGE, JOB_ERASE, JOB_ERAL, JOB_WRAL
  } mw_job_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_WEN   = 2'b11;
  localparam logic [1:0] EXT_WDIS  = 2'b00;
  localparam logic [1:0] EXT_ERAL  = 2'b10;
  localparam logic [1:0] EXT_WRAL  = 2'b01;

endpackage

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mw_engine.sv
`timescale 1ns/1ps
module mw_engine import mw_pkg::*; #(
  parameter int DW          = 8,
  parameter int AW          = 7,
  parameter int PGB         = 4,
  parameter int PROG_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  mw_job_e       go_job,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  input  logic          stg_we,
  input  logic [PGB-1:0] stg_idx,
  input  logic [DW-1:0] stg_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);

  localparam int DEPTH = 1 << AW;
  localparam int PG    = 1 << PGB;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic [DW-1:0]          mem_q [DEPTH];
  logic [PG-1:0][DW-1:0]  stg_q;
  logic [PG-1:0]          vld_q;

  logic                   busy_q, busy_n;
  logic [TW-1:0]          tmr_q, tmr_n;
  mw_job_e                job_q, job_n;
  logic [AW-1:0]          addr_q, addr_n;
  logic [DW-1:0]          data_q, data_n;
  logic                   done;

  logic [DEPTH-1:0]          wen;
  logic [DEPTH-1:0][DW-1:0]  wval;

  assign done = busy_q && (tmr_q == TW'(PROG_CYCLES - 1));

  always_comb begin
    busy_n = busy_q;
    tmr_n  = tmr_q;
    job_n  = job_q;
    addr_n = addr_q;
    data_n = data_q;
    if (go && !busy_q) begin
      busy_n = 1'b1;
      tmr_n  = '0;
      job_n  = go_job;
      addr_n = go_addr;
      data_n = go_data;
    end else if (busy_q) begin
      if (done) begin
        busy_n = 1'b0;
        job_n  = JOB_NONE;
      end else begin
        tmr_n = tmr_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      job_q  <= JOB_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_n;
      tmr_q  <= tmr_n;
      job_q  <= job_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  // Page staging buffer: filled word by word, emptied when a job ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      vld_q <= '0;
    end else begin
      if (done) vld_q <= '0;
      if (stg_we) begin
        stg_q[stg_idx] <= stg_data;
        vld_q[stg_idx] <= 1'b1;
      end
    end
  end

  // Per-location commit enable and value, applied in the final job cycle
  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    localparam logic [AW-1:0] GA = AW'(g);
    localparam int            GI = g % PG;
    assign wen[g] = done && (
        (job_q == JOB_ERAL) || (job_q == JOB_WRAL) ||
        ((job_q == JOB_ERASE) && (addr_q == GA)) ||
        ((job_q == JOB_PAGE) && vld_q[GI] && (addr_q[AW-1:PGB] == GA[AW-1:PGB])));
    assign wval[g] = (job_q == JOB_PAGE) ? stg_q[GI] :
                     (job_q == JOB_WRAL) ? data_q : {DW{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= {DW{1'b1}};
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wen[i]) mem_q[i] <= wval[i];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign busy    = busy_q;

endmodule

// File: rtl/mw_serial_fsm.sv
`timescale 1ns/1ps
module mw_serial_fsm import mw_pkg::*; #(
  parameter int DW  = 8,
  parameter int AW  = 7,
  parameter int PGB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_s,
  input  logic           sk_rise,
  input  logic           cs_fall,
  input  logic           di_s,
  input  logic           busy,
  input  logic [DW-1:0]  rd_data,
  output logic [AW-1:0]  rd_addr,
  output logic           stg_we,
  output logic [PGB-1:0] stg_idx,
  output logic [DW-1:0]  stg_data,
  output logic           go,
  output mw_job_e        go_job,
  output logic [AW-1:0]  go_addr,
  output logic [DW-1:0]  go_data,
  output logic           wel,
  output logic           do_o
);

  localparam int CW = $clog2((DW > AW) ? DW : AW);

  mw_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    opc_q, opc_n;
  logic [AW-1:0] ash_q, ash_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic [DW-1:0] dsh_q, dsh_n;
  logic          wel_q, wel_n;
  mw_job_e       job_q, job_n;
  logic [AW-1:0] jaddr_q, jaddr_n;
  logic [DW-1:0] jdata_q, jdata_n;
  logic          stat_q, stat_n;
  logic          do_q, do_n;

  logic          act;
  logic [AW-1:0] a_cat;
  logic [DW-1:0] d_cat;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    opc_n   = opc_q;
    ash_n   = ash_q;
    ptr_n   = ptr_q;
    dsh_n   = dsh_q;
    wel_n   = wel_q;
    job_n   = job_q;
    jaddr_n = jaddr_q;
    jdata_n = jdata_q;
    stat_n  = stat_q;
    do_n    = do_q;
    stg_we  = 1'b0;
    go      = 1'b0;

    act   = sk_rise && cs_s && !busy;
    a_cat = {ash_q[AW-2:0], di_s};
    d_cat = {dsh_q[DW-2:0], di_s};

    if (act) begin
      case (state_q)
        ST_IDLE: begin
          if (di_s) begin
            state_n = ST_OPC;
            cnt_n   = '0;
            stat_n  = 1'b0;
          end
        end
        ST_OPC: begin
          opc_n = {opc_q[0], di_s};
          if (cnt_q == CW'(1)) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        ST_ADDR: begin
          ash_n = a_cat;
          if (cnt_q == CW'(AW - 1)) begin
            cnt_n   = '0;
            state_n = ST_SKIP;
            case (opc_q)
              OPC_READ: begin
                state_n = ST_READ;
                ptr_n   = a_cat;
                cnt_n   = CW'(DW - 1);
                do_n    = 1'b0;
              end
              OPC_WRITE: begin
                if (wel_q) begin
                  state_n = ST_WDATA;
                  ptr_n   = a_cat;
                end
              end
              OPC_ERASE: begin
                if (wel_q) begin
                  job_n   = JOB_ERASE;
                  jaddr_n = a_cat;
                end
              end
              default: begin
                case (a_cat[AW-1 -: 2])
                  EXT_WEN:  wel_n = 1'b1;
                  EXT_WDIS: wel_n = 1'b0;
                  EXT_ERAL: if (wel_q) job_n = JOB_ERAL;
                  EXT_WRAL: if (wel_q) state_n = ST_WALL;
                  default:  ;
                endcase
              end
            endcase
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        ST_READ: begin
          do_n = rd_data[cnt_q];
          if (cnt_q == '0) begin
            cnt_n = CW'(DW - 1);
            ptr_n = ptr_q + AW'(1);
          end else begin
            cnt_n = cnt_q - CW'(1);
          end
        end
        ST_WDATA: begin
          dsh_n = d_cat;
          if (cnt_q == CW'(DW - 1)) begin
            stg_we  = 1'b1;
            job_n   = JOB_PAGE;
            jaddr_n = ptr_q;
            ptr_n   = {ptr_q[AW-1:PGB], ptr_q[PGB-1:0] + PGB'(1)};
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        ST_WALL: begin
          dsh_n = d_cat;
          if (cnt_q == CW'(DW - 1)) begin
            job_n   = JOB_WRAL;
            jdata_n = d_cat;
            state_n = ST_SKIP;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        default: ;
      endcase
    end

    if (!cs_s) state_n = ST_IDLE;

    if (cs_fall) begin
      go    = (job_q != JOB_NONE) && !busy;
      job_n = JOB_NONE;
      if (!busy) stat_n = 1'b0;
      if (go)    stat_n = 1'b1;
    end

    if (!cs_s)                   do_n = 1'b0;
    else if (stat_n)             do_n = !busy;
    else if (state_n != ST_READ) do_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      ash_q   <= '0;
      ptr_q   <= '0;
      dsh_q   <= '0;
      wel_q   <= 1'b0;
      job_q   <= JOB_NONE;
      jaddr_q <= '0;
      jdata_q <= '0;
      stat_q  <= 1'b0;
      do_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      opc_q   <= opc_n;
      ash_q   <= ash_n;
      ptr_q   <= ptr_n;
      dsh_q   <= dsh_n;
      wel_q   <= wel_n;
      job_q   <= job_n;
      jaddr_q <= jaddr_n;
      jdata_q <= jdata_n;
      stat_q  <= stat_n;
      do_q    <= do_n;
    end
  end

  assign rd_addr  = ptr_q;
  assign stg_idx  = ptr_q[PGB-1:0];
  assign stg_data = d_cat;
  assign go_job   = job_q;
  assign go_addr  = jaddr_q;
  assign go_data  = jdata_q;
  assign wel      = wel_q;
  assign do_o     = do_q;

endmodule

// File: rtl/mw_mem_slave.sv
`timescale 1ns/1ps
module mw_mem_slave import mw_pkg::*; #(
  parameter bit WORD16      = 1'b0,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);

  localparam int DW  = WORD16 ? 16 : 8;
  localparam int AW  = WORD16 ? 6 : 7;
  localparam int PGB = WORD16 ? 3 : 4;

  logic          cs_s, sk_s, di_s;
  logic          cs_d, sk_d;
  logic          sk_rise, cs_fall;
  logic          busy, wel;
  logic          go, stg_we;
  mw_job_e       go_job;
  logic [AW-1:0] go_addr, rd_addr;
  logic [DW-1:0] go_data, stg_data, rd_data;
  logic [PGB-1:0] stg_idx;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_i, sk_i, di_i}),
    .q     ({cs_s, sk_s, di_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d <= 1'b0;
      sk_d <= 1'b0;
    end else begin
      cs_d <= cs_s;
      sk_d <= sk_s;
    end
  end

  assign sk_rise = sk_s && !sk_d;
  assign cs_fall = !cs_s && cs_d;

  mw_serial_fsm #(.DW(DW), .AW(AW), .PGB(PGB)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sk_rise  (sk_rise),
    .cs_fall  (cs_fall),
    .di_s     (di_s),
    .busy     (busy),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .stg_we   (stg_we),
    .stg_idx  (stg_idx),
    .stg_data (stg_data),
    .go       (go),
    .go_job   (go_job),
    .go_addr  (go_addr),
    .go_data  (go_data),
    .wel      (wel),
    .do_o     (do_o)
  );

  mw_engine #(.DW(DW), .AW(AW), .PGB(PGB), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .go_job   (go_job),
    .go_addr  (go_addr),
    .go_data  (go_data),
    .stg_we   (stg_we),
    .stg_idx  (stg_idx),
    .stg_data (stg_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .busy     (busy)
  );

endmodule

// File: rtl/mw_checker.sv
`timescale 1ns/1ps
module mw_checker #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sk_rise,
  input logic cs_fall,
  input logic busy,
  input logic wel,
  input logic do_o
);

  localparam int BW = $clog2(PROG_CYCLES + 2) + 1;

  logic [BW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + BW'(1);
    else           busy_len <= '0;
  end

  // R8: a job begins only after select has fallen
  a_r8_start_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall));

  // R8: job length equals the parameter
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == BW'(PROG_CYCLES)));

  // R8: selected while busy gives a low status level
  a_r8_busy_shows_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(cs_s)) |-> !do_o);

  // R9: deselected block keeps data out low
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_s) |-> !do_o);

  // R2: the latch moves only on a serial clock edge
  a_r2_latch_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> $past(sk_rise));

  // R10: the latch holds while a job runs
  a_r10_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(wel));

endmodule

bind mw_mem_slave mw_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_s    (cs_s),
  .sk_rise (sk_rise),
  .cs_fall (cs_fall),
  .busy    (busy),
  .wel     (wel),
  .do_o    (do_o)
);

// File: tb/tb_mw_mem_slave.sv
`timescale 1ns/1ps
module tb_mw_mem_slave;

  localparam int PROG = 400;
  localparam int HALF = 6;
  localparam int GAP  = 4;

  logic clk, rst_n, cs, sk, di;
  logic do_o;

  int n_chk, n_bad, cyc, last_fall, job_fall;
  logic [7:0] exp_mem [128];

  mw_mem_slave #(.WORD16(1'b0), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(do_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic sk_bit(input logic b, output logic dout);
    @(negedge clk) di = b;
    repeat (HALF) @(negedge clk);
    sk = 1'b1;
    repeat (HALF) @(negedge clk);
    dout = do_o;
    sk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n, output logic last);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i], last);
  endtask

  task automatic select();
    chk((cyc - last_fall) >= GAP, "R8 deselect gap", cyc - last_fall, GAP);
    @(negedge clk) cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk) cs = 1'b0;
    last_fall = cyc;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [6:0] a);
    logic lb;
    select();
    send_bits({22'd0, 1'b1, op, a}, 10, lb);
    deselect();
  endtask

  task automatic wait_ready(input string req);
    int n;
    int el;
    select();
    chk(do_o == 1'b0, {req, " busy low"}, do_o, 0);
    n = 0;
    while (do_o !== 1'b1 && n < 3 * PROG) begin
      @(negedge clk);
      n++;
    end
    el = cyc - job_fall;
    chk(do_o == 1'b1 && el >= PROG && el <= PROG + 12, {req, " ready time"}, el, PROG);
    deselect();
  endtask

  task automatic check_idle(input string req);
    int hi;
    select();
    hi = 0;
    repeat (PROG + 20) begin
      @(negedge clk);
      if (do_o !== 1'b0) hi++;
    end
    chk(hi == 0, {req, " no job started"}, hi, 0);
    deselect();
  endtask

  task automatic read_chk(input logic [6:0] a, input int n, input string req);
    logic lb;
    logic [7:0] v;
    logic [6:0] ea;
    select();
    send_bits({22'd0, 1'b1, 2'b10, a}, 10, lb);
    chk(lb == 1'b0, "R3 dummy bit", lb, 0);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) sk_bit(1'b0, v[b]);
      ea = a + 7'(k);
      chk(v == exp_mem[ea], req, v, exp_mem[ea]);
    end
    deselect();
  endtask

  task automatic write_op(input logic [6:0] a, input logic [7:0] d [8], input int n,
                          input bit armed, input string req);
    logic lb;
    logic [6:0] wa;
    select();
    send_bits({22'd0, 1'b1, 2'b01, a}, 10, lb);
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) sk_bit(d[k][b], lb);
    deselect();
    job_fall = last_fall;
    if (armed) begin
      for (int k = 0; k < n; k++) begin
        wa = {a[6:4], a[3:0] + 4'(k)};
        exp_mem[wa] = d[k];
      end
      wait_ready(req);
    end else begin
      check_idle(req);
    end
  endtask

  task automatic t_reset();
    chk(do_o == 1'b0, "R1 reset data out", do_o, 0);
    read_chk(7'h05, 1, "R1 reset contents");
  endtask

  task automatic t_locked();
    logic [7:0] d [8];
    d = '{8'hA5, 0, 0, 0, 0, 0, 0, 0};
    write_op(7'h05, d, 1, 1'b0, "R1 locked write");
    read_chk(7'h05, 1, "R1 locked write unchanged");
  endtask

  task automatic t_enable_write();
    logic [7:0] d [8];
    cmd(2'b00, 7'b1100000);
    d = '{8'hA5, 0, 0, 0, 0, 0, 0, 0};
    write_op(7'h05, d, 1, 1'b1, "R5 single write");
    read_chk(7'h05, 1, "R5 single write");
    d = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
    write_op(7'h06, d, 1, 1'b1, "R2 latch persists");
    read_chk(7'h06, 1, "R2 latch persists");
  endtask

  task automatic t_page_wrap();
    logic [7:0] d [8];
    d = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 0, 0};
    write_op(7'h1C, d, 6, 1'b1, "R5 page write");
    read_chk(7'h1C, 4, "R5 page write top");
    read_chk(7'h10, 3, "R5 page wrap");
    read_chk(7'h20, 1, "R5 next page untouched");
  endtask

  task automatic t_cont_read();
    logic [7:0] d [8];
    d = '{8'h71, 8'h72, 0, 0, 0, 0, 0, 0};
    write_op(7'h7E, d, 2, 1'b1, "R4 setup high");
    d = '{8'h81, 8'h82, 0, 0, 0, 0, 0, 0};
    write_op(7'h00, d, 2, 1'b1, "R4 setup low");
    read_chk(7'h7E, 4, "R4 read wraps to 0");
  endtask

  task automatic t_erase();
    cmd(2'b11, 7'h05);
    job_fall = last_fall;
    exp_mem[7'h05] = 8'hFF;
    wait_ready("R6 erase one");
    read_chk(7'h05, 2, "R6 erase one");
  endtask

  task automatic t_disable();
    logic [7:0] d [8];
    cmd(2'b00, 7'b0000000);
    d = '{8'h33, 0, 0, 0, 0, 0, 0, 0};
    write_op(7'h06, d, 1, 1'b0, "R2 disabled write");
    read_chk(7'h06, 1, "R2 read while disabled");
    cmd(2'b11, 7'h1C);
    check_idle("R2 disabled erase");
    read_chk(7'h1C, 1, "R2 disabled erase unchanged");
    cmd(2'b00, 7'b1100000);
  endtask

  task automatic t_abort();
    logic lb;
    select();
    send_bits({25'd0, 1'b1, 2'b10, 3'b000}, 6, lb);
    deselect();
    read_chk(7'h06, 1, "R9 read after aborted command");
    select();
    send_bits({22'd0, 1'b1, 2'b01, 7'h30}, 10, lb);
    send_bits({28'd0, 4'hC}, 4, lb);
    deselect();
    check_idle("R9 partial word");
    read_chk(7'h30, 1, "R9 partial word discarded");
  endtask

  task automatic t_wral_busy();
    logic lb;
    int lows;
    select();
    send_bits({22'd0, 1'b1, 2'b00, 7'b0100000}, 10, lb);
    send_bits({24'd0, 8'h3C}, 8, lb);
    deselect();
    job_fall = last_fall;
    select();
    lows = 0;
    for (int i = 17; i >= 0; i--) begin
      sk_bit(i >= 8 ? ((i == 17) || (i == 15)) : 1'b0, lb);
      if (lb !== 1'b0) lows++;
    end
    chk(lows == 0, "R8 busy level during job", lows, 0);
    deselect();
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h3C;
    wait_ready("R7 write all");
    read_chk(7'h00, 1, "R7 write all");
    read_chk(7'h40, 1, "R10 write while busy ignored");
    read_chk(7'h7F, 1, "R7 write all top");
  endtask

  task automatic t_eral();
    cmd(2'b00, 7'b1000000);
    job_fall = last_fall;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
    wait_ready("R6 erase all");
    read_chk(7'h00, 1, "R6 erase all");
    read_chk(7'h55, 1, "R6 erase all mid");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    summary();
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    cyc = 0;
    last_fall = -100;
    job_fall = 0;
    cs = 1'b0;
    sk = 1'b0;
    di = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_locked();
    t_enable_write();
    t_page_wrap();
    t_cont_read();
    t_erase();
    t_disable();
    t_abort();
    t_wral_busy();
    t_eral();
    summary();
    $finish;
  end

endmodule